// File: doc/BRIEF.md
# Serial Clock Generator with Split Phase Counts

This block derives a serial interface clock from the source clock for a shift engine. The clock register word sets two 6-bit counts. The period count gives the length of one serial clock cycle. The high count gives how long the clock stays high within that cycle. Because the two counts are independent, software sets the duty cycle directly and is not tied to a fixed divide-by-two. Software normally programs period = n and high = (n+1)/2 - 1, which gives a duty cycle near 50%. The fastest setting divides the source clock by 2 and the slowest by 64.

While the enable input is high, the block runs a low phase and then a high phase, and repeats. While enable is low, the clock is held low. The block raises a one-cycle strobe on every rising edge of the serial clock and on every falling edge, so a shift engine can sample and launch data on those cycles. The clock register is captured into a shadow copy at the start of a burst and again at each period boundary. A rewrite in the middle of a period therefore cannot produce a short pulse. The source select bit is passed out from the same shadow copy, to drive a clock mux outside the block.

Top module: `sckgen_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `sck_o`, `sck_rise_o`, `sck_fall_o` and `src_sel_o` are all 0.
- R2: In every cycle that follows a clock edge where `en_i` was sampled low, `sck_o` is 0.
- R3: Let P be the period count (bits [5:0]) and H the high count (bits [11:6]), with 1 <= P and H < P. Each serial clock cycle then lasts P+1 source cycles: first P-H cycles low, then H+1 cycles high.
- R4: At the first clock edge that samples `en_i` high, the phase counter restarts. `sck_o` then stays low for a full low phase of P-H cycles before its first rising edge.
- R5: The clock register word is captured only at the start of a burst and at the edge that ends a period. A change to the word during a period has no effect until the next period begins.
- R6: A period count of 0 is treated as 1. A high count that is greater than or equal to the effective period count is treated as the effective period count minus 1.
- R7: `sck_rise_o` is 1 in exactly those cycles where `sck_o` is 1 and was 0 in the cycle before. `sck_fall_o` is 1 in exactly those cycles where `sck_o` is 0 and was 1 in the cycle before.
- R8: `src_sel_o` shows bit 31 of the word most recently captured under R5.
- R9: Bits [30:12] of the clock register word, which include a 6-bit divider field at [17:12], have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Source clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Burst active; clock runs while high |
| clk_cfg_i | input | 32 | Clock register word: [5:0] period count, [11:6] high count, [31] source select |
| sck_o | output | 1 | Serial clock, idle low |
| sck_rise_o | output | 1 | One-cycle strobe on each rising edge of sck_o |
| sck_fall_o | output | 1 | One-cycle strobe on each falling edge of sck_o |
| src_sel_o | output | 1 | Captured source select bit |

## Verification
The assertions check on every cycle:
- that the clock is low after a low enable and at the start of a burst;
- that the phase counter never passes the captured period;
- that the shadow copy holds still in the middle of a period;
- that each edge strobe matches a real transition of the clock.

Exact phase lengths, the clamping of out-of-range counts, the handling of the divider and other unused bits, and the point at which a mid-period rewrite takes effect can only be shown by the bench. It compares every output against a behavioural reference model on every cycle and also measures low phases and periods directly.

// File: rtl/sckgen_pkg.sv
package sckgen_pkg;
  localparam int CNT_W   = 6;
  localparam int CFG_W   = 32;
  localparam int PER_LSB = 0;
  localparam int HI_LSB  = PER_LSB + CNT_W;
  localparam int SEL_BIT = CFG_W - 1;

  typedef struct packed {
    logic             sel;
    logic [CNT_W-1:0] per;
    logic [CNT_W-1:0] hi;
  } sck_cfg_t;

  // Extract fields and clamp to a legal shape (per >= 1, hi < per)
  function automatic sck_cfg_t decode_cfg(logic [CFG_W-1:0] w);
    sck_cfg_t c;
    c.sel = w[SEL_BIT];
    c.per = w[PER_LSB +: CNT_W];
    c.hi  = w[HI_LSB +: CNT_W];
    if (c.per == '0) c.per = CNT_W'(1);
    if (c.hi >= c.per) c.hi = c.per - CNT_W'(1);
    return c;
  endfunction
endpackage

// File: rtl/sckgen_shadow.sv
module sckgen_shadow
  import sckgen_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CFG_W-1:0] cfg_word_i,
  output sck_cfg_t         cfg_o
);
  sck_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q.sel <= 1'b0;
      cfg_q.per <= CNT_W'(1);
      cfg_q.hi  <= '0;
    end else if (load_i) begin
      cfg_q <= decode_cfg(cfg_word_i);
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/sckgen_phase.sv
module sckgen_phase
  import sckgen_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     en_i,
  input  sck_cfg_t cfg_i,
  output logic     load_o,
  output logic     sck_o,
  output logic     sck_nxt_o
);
  localparam int EXT_W = CNT_W + 1;

  logic             run_q;
  logic [CNT_W-1:0] cnt_q;
  logic             sck_q;
  logic             wrap;
  logic [EXT_W-1:0] cnt_inc;
  logic [EXT_W-1:0] low_len;
  logic             sck_nxt;

  assign wrap    = run_q && (cnt_q == cfg_i.per);
  assign load_o  = en_i && (!run_q || wrap);
  assign cnt_inc = {1'b0, cnt_q} + EXT_W'(1);
  assign low_len = {1'b0, cfg_i.per - cfg_i.hi};

  always_comb begin
    if (!en_i || !run_q || wrap) sck_nxt = 1'b0;
    else                         sck_nxt = (cnt_inc >= low_len);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else begin
      sck_q <= sck_nxt;
      if (!en_i) begin
        run_q <= 1'b0;
        cnt_q <= '0;
      end else if (!run_q || wrap) begin
        run_q <= 1'b1;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_inc[CNT_W-1:0];
      end
    end
  end

  assign sck_o     = sck_q;
  assign sck_nxt_o = sck_nxt;

  assert_idle_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !sck_o);
  assert_start_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !run_q) |=> !sck_o);
  assert_cnt_in_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (cnt_q <= cfg_i.per));
  assert_shadow_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && run_q && !wrap) |=> $stable(cfg_i));
endmodule

// File: rtl/sckgen_edge.sv
module sckgen_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic sck_nxt_i,
  output logic rise_o,
  output logic fall_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_o <= 1'b0;
      fall_o <= 1'b0;
    end else begin
      rise_o <= sck_nxt_i & ~sck_i;
      fall_o <= ~sck_nxt_i & sck_i;
    end
  end
endmodule

// File: rtl/sckgen_top.sv
module sckgen_top
  import sckgen_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CFG_W-1:0] clk_cfg_i,
  output logic             sck_o,
  output logic             sck_rise_o,
  output logic             sck_fall_o,
  output logic             src_sel_o
);
  sck_cfg_t shadow;
  logic     load;
  logic     sck_nxt;

  sckgen_shadow u_shadow (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .cfg_word_i (clk_cfg_i),
    .cfg_o      (shadow)
  );

  sckgen_phase u_phase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .cfg_i     (shadow),
    .load_o    (load),
    .sck_o     (sck_o),
    .sck_nxt_o (sck_nxt)
  );

  sckgen_edge u_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sck_i     (sck_o),
    .sck_nxt_i (sck_nxt),
    .rise_o    (sck_rise_o),
    .fall_o    (sck_fall_o)
  );

  assign src_sel_o = shadow.sel;

  assert_rise_tracks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sck_o) |-> sck_rise_o);
  assert_fall_tracks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sck_o) |-> sck_fall_o);
  assert_rise_valid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_rise_o |-> sck_o);
  assert_fall_valid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_fall_o |-> !sck_o);
endmodule

// File: tb/sckgen_tb_top.sv
module sckgen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic [31:0] clk_cfg_i = 32'h0;
  logic        sck_o, sck_rise_o, sck_fall_o, src_sel_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string cur_req = "R3";

  sckgen_top dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .clk_cfg_i(clk_cfg_i),
    .sck_o(sck_o), .sck_rise_o(sck_rise_o), .sck_fall_o(sck_fall_o),
    .src_sel_o(src_sel_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // Behavioural reference model
  int m_run, m_pos, m_per, m_hi, m_sel, m_sck, m_prev, m_rise, m_fall;

  function automatic void m_capture(logic [31:0] w);
    m_per = int'(w[5:0]);
    if (m_per == 0) m_per = 1;
    m_hi = int'(w[11:6]);
    if (m_hi >= m_per) m_hi = m_per - 1;
    m_sel = int'(w[31]);
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_run = 0; m_pos = 0; m_per = 1; m_hi = 0; m_sel = 0;
      m_sck = 0; m_prev = 0; m_rise = 0; m_fall = 0;
    end else begin
      cycles++;
      m_prev = m_sck;
      if (!en_i) begin
        m_run = 0; m_sck = 0;
      end else if (m_run == 0) begin
        m_run = 1; m_pos = 0; m_capture(clk_cfg_i); m_sck = 0;
      end else begin
        if (m_pos == m_per) begin
          m_pos = 0; m_capture(clk_cfg_i);
        end else m_pos++;
        m_sck = (m_pos >= m_per - m_hi) ? 1 : 0;
      end
      m_rise = (m_sck == 1 && m_prev == 0) ? 1 : 0;
      m_fall = (m_sck == 0 && m_prev == 1) ? 1 : 0;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni) begin
      check(cur_req, "sck_o vs model", int'(sck_o), m_sck);
      check("R7", "sck_rise_o vs model", int'(sck_rise_o), m_rise);
      check("R7", "sck_fall_o vs model", int'(sck_fall_o), m_fall);
      check("R8", "src_sel_o vs model", int'(src_sel_o), m_sel);
    end
  end

  function automatic logic [31:0] cfg(int per, int hi, logic sel, int divf);
    return {sel, 13'h0, 6'(divf), 6'(hi), 6'(per)};
  endfunction

  // Cycles from now (at negedge) until the next rise strobe
  task automatic wait_rise(output int n);
    n = 0;
    do begin @(negedge clk_i); n++; end while (!sck_rise_o && n < 500);
  endtask

  task automatic idle(int n);
    en_i = 1'b0;
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk_i);
    check("R1", "sck_o in reset", int'(sck_o), 0);
    check("R1", "strobes in reset", int'(sck_rise_o | sck_fall_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", "src_sel_o after reset", int'(src_sel_o), 0);

    // R4: full low phase before the first rise (per 9, hi 3 -> low 6)
    cur_req = "R4";
    clk_cfg_i = cfg(9, 3, 1'b0, 0);
    en_i = 1'b1;
    wait_rise(n);
    check("R4", "cycles to first rise", n, 7);
    // R3: rise-to-rise spacing is per+1
    cur_req = "R3";
    wait_rise(n);
    check("R3", "period per=9", n, 10);
    idle(3);
    check("R2", "sck low while disabled", int'(sck_o), 0);

    // R3: fastest and slowest settings
    clk_cfg_i = cfg(1, 0, 1'b0, 0);
    en_i = 1'b1;
    wait_rise(n); wait_rise(n);
    check("R3", "period /2", n, 2);
    idle(2);
    clk_cfg_i = cfg(63, 31, 1'b0, 0);
    en_i = 1'b1;
    wait_rise(n);
    check("R4", "first rise /64", n, 33);
    wait_rise(n);
    check("R3", "period /64", n, 64);

    // R2: disable during the high phase
    cur_req = "R2";
    repeat (5) @(negedge clk_i);
    en_i = 1'b0;
    @(negedge clk_i);
    check("R2", "sck low after disable", int'(sck_o), 0);
    idle(2);

    // R6: clamping of out-of-range counts
    cur_req = "R6";
    clk_cfg_i = cfg(0, 7, 1'b0, 0);
    en_i = 1'b1;
    wait_rise(n); wait_rise(n);
    check("R6", "per 0 treated as 1", n, 2);
    idle(2);
    clk_cfg_i = cfg(4, 9, 1'b0, 0);
    en_i = 1'b1;
    wait_rise(n);
    check("R6", "hi>=per low phase 1", n, 2);
    idle(2);

    // R5: mid-period rewrite waits for the boundary; R8 select follows
    cur_req = "R5";
    clk_cfg_i = cfg(20, 9, 1'b1, 0);
    en_i = 1'b1;
    repeat (4) @(negedge clk_i);
    clk_cfg_i = cfg(3, 1, 1'b0, 0);
    @(negedge clk_i);
    check("R8", "select held mid-period", int'(src_sel_o), 1);
    wait_rise(n);
    check("R5", "old low phase kept", n, 7);
    wait_rise(n);
    check("R5", "first new period after boundary", n, 12);
    wait_rise(n);
    check("R5", "new period", n, 4);
    check("R8", "select updated at boundary", int'(src_sel_o), 0);

    // R9: divider field and upper bits ignored
    cur_req = "R9";
    clk_cfg_i = cfg(5, 2, 1'b0, 63) | 32'h7ffc0000;
    repeat (4) wait_rise(n);
    check("R9", "period with divider bits set", n, 6);
    clk_cfg_i = cfg(5, 2, 1'b0, 1);
    repeat (3) wait_rise(n);
    check("R9", "period with divider bits changed", n, 6);
    idle(4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles >= WATCHDOG);
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule